// File: doc/BRIEF.md
# Four-Port Shared-Bus Cell Interface (PHY Side)

This block sits on the PHY side of an 8-bit, level-one style cell bus. Four ports share one receive byte bus and one transmit byte bus. Each port has its own active-low enable and its own cell-available flag in each direction. On the receive side, the block pops 53-byte cells from the FIFO of the port that the ATM-layer device selects. It presents each byte with odd parity and marks the first byte of every cell. On the transmit side, it writes incoming bytes into the selected port's FIFO, tagging each byte as the first or last of its cell. It checks odd parity on every byte and records parity errors in a per-port interrupt status vector, which software clears by writing ones.

The receive and transmit halves run on separate free-running clocks, and each has its own synchronous active-high reset. The FIFOs sit outside the block. A receive FIFO is show-ahead: it presents its head byte and reports whether a whole cell is waiting. A transmit FIFO reports whether it has room for a whole cell. An idle-float control bit lets the receive data, parity and start-of-cell pads go to high impedance while no port is selected. The block produces the pad output enable for this.

Top module: `utp_l1_phy`

## Requirements
- R1: `rx_clav[p]` equals `rx_cell_rdy[p]` and `tx_clav[p]` equals `tx_room[p]`, each as sampled at the previous edge of its own clock. Both flags are 0 after reset.
- R2: At an `rx_clk` edge, the lowest-numbered port p with `rx_en_n[p]` low is selected. A byte moves from that port only when port p is mid-cell or `rx_cell_rdy[p]` is 1. `rx_pop[p]` is high in the cycle before that edge. The byte, which is `rx_fifo_byte[8p+7:8p]`, appears on `rx_data` after the edge.
- R3: `rx_soc` is 1 exactly with the first byte of each cell. A cell is 53 bytes. Once a cell's 53rd byte has moved, the port needs `rx_cell_rdy` again to start another cell.
- R4: `rx_par` makes the 9 bits {`rx_data`, `rx_par`} contain an odd number of ones. After reset, `rx_data` is 0 and `rx_par` is 1.
- R5: When a port's enable goes high mid-cell, `rx_data` holds its value and that port does not pop. The cell resumes with the next byte and no second start-of-cell marker. Each port keeps its own position in its cell while another port is served.
- R6: `rx_oe` goes to 0 after an edge where `rx_float_idle` is 1 and all `rx_en_n` bits are 1. At any other edge, `rx_oe` goes to 1. It is 1 after reset.
- R7: If the selected receive port is not mid-cell and has no cell ready, nothing moves: there is no pop, `rx_soc` stays 0 and `rx_data` holds.
- R8: At a `tx_clk` edge, the lowest-numbered port p with `tx_en_n[p]` low is selected. An accepted byte produces, one cycle later, `tx_wr` equal to one-hot p and `tx_wr_data` equal to the byte.
- R9: A transmit cell begins on a byte with `tx_soc` high. A selected byte outside a cell that lacks `tx_soc` is dropped, so `tx_wr` stays 0. `tx_soc` in mid-cell restarts the count. `tx_wr_first` flags the start byte and `tx_wr_last` flags the 53rd byte.
- R10: A selected transmit byte whose 9 bits {`tx_data`, `tx_par`} hold an even count of ones sets `tx_irq_stat[p]` at the next edge, but only if `tx_perr_en[p]` is 1. The byte is still handled as usual.
- R11: A 1 on `tx_irq_clr[p]` clears `tx_irq_stat[p]`. If a set and a clear for the same bit arrive at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive free-running clock |
| rx_rst | input | 1 | Receive synchronous reset, active high |
| rx_en_n | input | N | Per-port receive enable, active low |
| rx_cell_rdy | input | N | Per-port flag from the receive FIFO: a whole cell is waiting |
| rx_fifo_byte | input | N*DW | Head bytes of the receive FIFOs, port p at bits 8p+7:8p |
| rx_float_idle | input | 1 | Float the receive pads while no port is selected |
| rx_pop | output | N | Per-port receive FIFO pop strobe |
| rx_clav | output | N | Per-port receive cell-available |
| rx_data | output | DW | Shared receive byte bus |
| rx_par | output | 1 | Odd parity over rx_data |
| rx_soc | output | 1 | Receive start-of-cell marker |
| rx_oe | output | 1 | Output enable for rx_data, rx_par and rx_soc pads |
| tx_clk | input | 1 | Transmit free-running clock |
| tx_rst | input | 1 | Transmit synchronous reset, active high |
| tx_en_n | input | N | Per-port transmit enable, active low |
| tx_data | input | DW | Shared transmit byte bus |
| tx_par | input | 1 | Odd parity over tx_data |
| tx_soc | input | 1 | Transmit start-of-cell marker |
| tx_room | input | N | Per-port flag from the transmit FIFO: room for a whole cell |
| tx_perr_en | input | N | Per-port parity interrupt enable |
| tx_irq_clr | input | N | Per-port write-one-to-clear strobe for tx_irq_stat |
| tx_clav | output | N | Per-port transmit cell-available |
| tx_wr | output | N | One-hot transmit FIFO write strobe |
| tx_wr_data | output | DW | Byte to write into the transmit FIFO |
| tx_wr_first | output | 1 | Written byte is the first of its cell |
| tx_wr_last | output | 1 | Written byte is the last of its cell |
| tx_irq_stat | output | N | Per-port transmit parity error status |

## Verification
Every registered result is due one clock after the edge that sampled its cause. This covers the receive byte, parity and start-of-cell marker, both cell-available vectors, the pad enable, the transmit write with its first and last tags, and the interrupt status bits. The receive pop strobe is the one exception: it is combinational and is counted at the same edge. The driver tags each expected item with the number of the edge that will produce it, plus one. The monitor samples on the falling clock edge and compares an item only when the cycle counter equals its tag. In every other cycle, it checks that the receive bus holds its value, `rx_soc` is 0 and no transmit write fires. Flags that follow their inputs by one edge are compared against small bench registers that are updated on the rising edge.

// File: rtl/utp_pkg.sv
package utp_pkg;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int lowest_set(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/utp_cell_count.sv
module utp_cell_count #(
  parameter int CELL = 53
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic restart,
  output logic busy,
  output logic at_last
);
  localparam int CW = (CELL > 1) ? $clog2(CELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(CELL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (adv) begin
      if (restart)          cnt <= (CELL > 1) ? CW'(1) : '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + CW'(1);
    end
  end

  assign busy    = (cnt != '0);
  assign at_last = (cnt == LAST);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

endmodule

// File: rtl/utp_rx_path.sv
module utp_rx_path
  import utp_pkg::*;
#(
  parameter int N    = 4,
  parameter int CELL = 53,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  en_n,
  input  logic [N-1:0]  cell_rdy,
  input  logic [N*DW-1:0] fifo_byte,
  input  logic          float_idle,
  output logic [N-1:0]  fifo_pop,
  output logic [N-1:0]  clav,
  output logic [DW-1:0] data_q,
  output logic          par_q,
  output logic          soc_q,
  output logic          oe_q
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  act, mid, lastv, go;
  logic          any;
  logic [PW-1:0] sel;
  logic [DW-1:0] pbyte;

  assign act   = ~en_n;
  assign any   = |act;
  assign sel   = PW'(lowest_set(32'(act)));
  assign pbyte = fifo_byte[int'(sel)*DW +: DW];

  for (genvar g = 0; g < N; g++) begin : g_port
    assign go[g] = !rst && any && (sel == PW'(g)) && (mid[g] || cell_rdy[g]);

    utp_cell_count #(.CELL(CELL)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .adv    (go[g]),
      .restart(1'b0),
      .busy   (mid[g]),
      .at_last(lastv[g])
    );

    // R3
    rx_cell_end_chk: assert property (@(posedge clk) disable iff (rst)
      (go[g] && lastv[g]) |=> !mid[g]);
  end

  assign fifo_pop = go;

  always_ff @(posedge clk) begin
    if (rst) begin
      clav   <= '0;
      data_q <= '0;
      par_q  <= 1'b1;
      soc_q  <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      clav  <= cell_rdy;
      oe_q  <= !(float_idle && !any);
      soc_q <= |(go & ~mid);
      if (|go) begin
        data_q <= pbyte;
        par_q  <= ~^pbyte;
      end
    end
  end

  // R4
  rx_parity_chk: assert property (@(posedge clk) disable iff (rst) ^{data_q, par_q});
  // R3
  rx_soc_src_chk: assert property (@(posedge clk) disable iff (rst) soc_q |-> $past(|go));
  // R6
  rx_float_chk: assert property (@(posedge clk) disable iff (rst)
    (float_idle && !any) |=> !oe_q);
  // R2
  rx_start_chk: assert property (@(posedge clk) disable iff (rst)
    (go & ~mid & ~cell_rdy) == '0);

endmodule

// File: rtl/utp_tx_path.sv
module utp_tx_path
  import utp_pkg::*;
#(
  parameter int N    = 4,
  parameter int CELL = 53,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  en_n,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_par,
  input  logic          bus_soc,
  input  logic [N-1:0]  room,
  input  logic [N-1:0]  perr_en,
  input  logic [N-1:0]  irq_clr,
  output logic [N-1:0]  clav,
  output logic [N-1:0]  wr,
  output logic [DW-1:0] wr_data,
  output logic          wr_first,
  output logic          wr_last,
  output logic [N-1:0]  irq_stat
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  act, take, accept, mid, lastv, ends;
  logic          any, perr;
  logic [PW-1:0] sel;

  assign act  = ~en_n;
  assign any  = |act;
  assign sel  = PW'(lowest_set(32'(act)));
  assign perr = ~(^{bus_data, bus_par});

  for (genvar g = 0; g < N; g++) begin : g_port
    assign take[g]   = !rst && any && (sel == PW'(g));
    assign accept[g] = take[g] && (mid[g] || bus_soc);
    assign ends[g]   = accept[g] && (bus_soc ? (CELL == 1) : lastv[g]);

    utp_cell_count #(.CELL(CELL)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .adv    (accept[g]),
      .restart(bus_soc),
      .busy   (mid[g]),
      .at_last(lastv[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clav     <= '0;
      wr       <= '0;
      wr_data  <= '0;
      wr_first <= 1'b0;
      wr_last  <= 1'b0;
      irq_stat <= '0;
    end else begin
      clav     <= room;
      wr       <= accept;
      wr_first <= bus_soc && (|accept);
      wr_last  <= |ends;
      if (|accept) wr_data <= bus_data;
      irq_stat <= (irq_stat & ~irq_clr) | (take & perr_en & {N{perr}});
    end
  end

  // R9
  tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(take & ~mid)) && !bus_soc) |=> !(|wr));
  // R10
  tx_irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|(irq_stat & ~$past(irq_stat))) |-> $past(perr && any));
  // R8
  tx_wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (|wr) |-> $past(any));

endmodule

// File: rtl/utp_l1_phy.sv
module utp_l1_phy #(
  parameter int N    = 4,
  parameter int CELL = 53,
  parameter int DW   = 8
) (
  input  logic            rx_clk,
  input  logic            rx_rst,
  input  logic [N-1:0]    rx_en_n,
  input  logic [N-1:0]    rx_cell_rdy,
  input  logic [N*DW-1:0] rx_fifo_byte,
  input  logic            rx_float_idle,
  output logic [N-1:0]    rx_pop,
  output logic [N-1:0]    rx_clav,
  output logic [DW-1:0]   rx_data,
  output logic            rx_par,
  output logic            rx_soc,
  output logic            rx_oe,
  input  logic            tx_clk,
  input  logic            tx_rst,
  input  logic [N-1:0]    tx_en_n,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_par,
  input  logic            tx_soc,
  input  logic [N-1:0]    tx_room,
  input  logic [N-1:0]    tx_perr_en,
  input  logic [N-1:0]    tx_irq_clr,
  output logic [N-1:0]    tx_clav,
  output logic [N-1:0]    tx_wr,
  output logic [DW-1:0]   tx_wr_data,
  output logic            tx_wr_first,
  output logic            tx_wr_last,
  output logic [N-1:0]    tx_irq_stat
);

  utp_rx_path #(.N(N), .CELL(CELL), .DW(DW)) u_rx (
    .clk       (rx_clk),
    .rst       (rx_rst),
    .en_n      (rx_en_n),
    .cell_rdy  (rx_cell_rdy),
    .fifo_byte (rx_fifo_byte),
    .float_idle(rx_float_idle),
    .fifo_pop  (rx_pop),
    .clav      (rx_clav),
    .data_q    (rx_data),
    .par_q     (rx_par),
    .soc_q     (rx_soc),
    .oe_q      (rx_oe)
  );

  utp_tx_path #(.N(N), .CELL(CELL), .DW(DW)) u_tx (
    .clk      (tx_clk),
    .rst      (tx_rst),
    .en_n     (tx_en_n),
    .bus_data (tx_data),
    .bus_par  (tx_par),
    .bus_soc  (tx_soc),
    .room     (tx_room),
    .perr_en  (tx_perr_en),
    .irq_clr  (tx_irq_clr),
    .clav     (tx_clav),
    .wr       (tx_wr),
    .wr_data  (tx_wr_data),
    .wr_first (tx_wr_first),
    .wr_last  (tx_wr_last),
    .irq_stat (tx_irq_stat)
  );

endmodule

// File: tb/sim_utp_l1_phy.sv
module sim_utp_l1_phy;
  localparam int N = 4, CELL = 53, DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst;

  logic [N-1:0]    rx_en_n, rx_cell_rdy, rx_pop, rx_clav;
  logic [N*DW-1:0] rx_fifo_byte;
  logic            rx_float_idle, rx_par, rx_soc, rx_oe;
  logic [DW-1:0]   rx_data;
  logic [N-1:0]    tx_en_n, tx_room, tx_perr_en, tx_irq_clr, tx_clav, tx_wr, tx_irq_stat;
  logic [DW-1:0]   tx_data, tx_wr_data;
  logic            tx_par, tx_soc, tx_wr_first, tx_wr_last;

  utp_l1_phy #(.N(N), .CELL(CELL), .DW(DW)) u0 (
    .rx_clk(clk), .rx_rst(rst), .rx_en_n(rx_en_n), .rx_cell_rdy(rx_cell_rdy),
    .rx_fifo_byte(rx_fifo_byte), .rx_float_idle(rx_float_idle), .rx_pop(rx_pop),
    .rx_clav(rx_clav), .rx_data(rx_data), .rx_par(rx_par), .rx_soc(rx_soc), .rx_oe(rx_oe),
    .tx_clk(clk), .tx_rst(rst), .tx_en_n(tx_en_n), .tx_data(tx_data), .tx_par(tx_par),
    .tx_soc(tx_soc), .tx_room(tx_room), .tx_perr_en(tx_perr_en), .tx_irq_clr(tx_irq_clr),
    .tx_clav(tx_clav), .tx_wr(tx_wr), .tx_wr_data(tx_wr_data), .tx_wr_first(tx_wr_first),
    .tx_wr_last(tx_wr_last), .tx_irq_stat(tx_irq_stat)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] gen(input int p, input int k);
    return 8'((p * 61 + k * 29 + 17) % 256);
  endfunction

  function automatic int pick(input logic [N-1:0] en);
    for (int i = 0; i < N; i++) if (!en[i]) return i;
    return -1;
  endfunction

  function automatic logic [N-1:0] irq_set(input logic [N-1:0] en, input logic [7:0] d,
                                           input logic p, input logic [N-1:0] pe);
    int s;
    s = pick(en);
    if (s >= 0 && (^{d, p}) == 1'b0 && pe[s]) return N'(1) << s;
    return '0;
  endfunction

  // Receive FIFO models: show-ahead, pointer advanced by the pop strobe
  int rptr [N];
  always_comb for (int p = 0; p < N; p++) rx_fifo_byte[p*DW +: DW] = gen(p, rptr[p]);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int p = 0; p < N; p++) rptr[p] <= 0;
    end else begin
      for (int p = 0; p < N; p++) if (rx_pop[p]) rptr[p] <= rptr[p] + 1;
    end
  end

  // One-edge-delay flag models
  logic oe_m;
  logic [N-1:0] rclav_m, tclav_m, irq_m;
  always @(posedge clk) begin
    if (rst) begin
      oe_m <= 1'b1; rclav_m <= '0; tclav_m <= '0; irq_m <= '0;
    end else begin
      oe_m    <= !(rx_float_idle && (&rx_en_n));
      rclav_m <= rx_cell_rdy;
      tclav_m <= tx_room;
      irq_m   <= (irq_m & ~tx_irq_clr) | irq_set(tx_en_n, tx_data, tx_par, tx_perr_en);
    end
  end

  // Scoreboard
  typedef struct { int due; logic [7:0] d; logic soc; } rx_item_t;
  typedef struct { int due; int port; logic [7:0] d; logic first; logic last; } tx_item_t;
  rx_item_t rxq[$];
  tx_item_t txq[$];
  int erx_ptr [N];
  int erx_cnt [N];
  int etx_cnt [N];
  logic [7:0] rx_last = 8'h00;

  task automatic rx_step(input logic [N-1:0] en, input logic [N-1:0] rdy);
    int s;
    @(negedge clk);
    rx_en_n = en;
    rx_cell_rdy = rdy;
    s = pick(en);
    if (s >= 0 && (erx_cnt[s] != 0 || rdy[s])) begin
      rxq.push_back('{due: cyc + 1, d: gen(s, erx_ptr[s]), soc: (erx_cnt[s] == 0)});
      erx_ptr[s]++;
      erx_cnt[s] = (erx_cnt[s] == CELL - 1) ? 0 : erx_cnt[s] + 1;
    end
  endtask

  task automatic tx_step(input logic [N-1:0] en, input logic [7:0] d, input logic soc,
                         input logic bad, input logic [N-1:0] clr);
    int s, c;
    logic last;
    @(negedge clk);
    tx_en_n = en; tx_data = d; tx_soc = soc; tx_irq_clr = clr;
    tx_par = bad ? (^d) : ~(^d);
    s = pick(en);
    if (s >= 0 && (etx_cnt[s] != 0 || soc)) begin
      c = soc ? 0 : etx_cnt[s];
      last = (c == CELL - 1);
      txq.push_back('{due: cyc + 1, port: s, d: d, first: soc, last: last});
      etx_cnt[s] = last ? 0 : c + 1;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rxq.size() > 0 && rxq[0].due == cyc) begin
        rx_item_t it;
        it = rxq.pop_front();
        chk("R2 rx byte", 32'(rx_data), 32'(it.d));
        chk("R4 rx parity", 32'(rx_par), 32'(~^it.d));
        chk("R3 rx start marker", 32'(rx_soc), 32'(it.soc));
        rx_last = it.d;
      end else begin
        chk("R5 rx bus holds", 32'(rx_data), 32'(rx_last));
        chk("R7 rx no marker when idle", 32'(rx_soc), 0);
      end
      if (txq.size() > 0 && txq[0].due == cyc) begin
        tx_item_t t;
        t = txq.pop_front();
        chk("R8 tx write port", 32'(tx_wr), 32'(N'(1) << t.port));
        chk("R8 tx write byte", 32'(tx_wr_data), 32'(t.d));
        chk("R9 tx first tag", 32'(tx_wr_first), 32'(t.first));
        chk("R9 tx last tag", 32'(tx_wr_last), 32'(t.last));
      end else begin
        chk("R9 tx no write", 32'(tx_wr), 0);
      end
      chk("R6 rx pad enable", 32'(rx_oe), 32'(oe_m));
      chk("R1 rx clav", 32'(rx_clav), 32'(rclav_m));
      chk("R1 tx clav", 32'(tx_clav), 32'(tclav_m));
      chk("R10 R11 irq status", 32'(tx_irq_stat), 32'(irq_m));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int p = 0; p < N; p++) begin erx_ptr[p] = 0; erx_cnt[p] = 0; etx_cnt[p] = 0; end
    rst = 1'b1;
    rx_en_n = '1; rx_cell_rdy = '0; rx_float_idle = 1'b0;
    tx_en_n = '1; tx_data = '0; tx_par = 1'b1; tx_soc = 1'b0;
    tx_room = '0; tx_perr_en = '0; tx_irq_clr = '0;
    repeat (3) @(negedge clk);
    // Reset state (R1, R4, R6)
    chk("R6 reset pad enable", 32'(rx_oe), 1);
    chk("R4 reset rx parity", 32'(rx_par), 1);
    chk("R4 reset rx data", 32'(rx_data), 0);
    chk("R1 reset clav", 32'({rx_clav, tx_clav}), 0);
    chk("R9 reset no write", 32'(tx_wr), 0);
    chk("R10 reset irq", 32'(tx_irq_stat), 0);
    rst = 1'b0;

    // R1: flag patterns
    tx_room = 4'b0110;
    rx_step(4'b1111, 4'b1010);
    tx_room = 4'b1001;
    rx_step(4'b1111, 4'b0101);

    // R2 R3 R4: one full cell on port 1
    for (int i = 0; i < CELL; i++) rx_step(4'b1101, 4'b0010);
    // R7: enabled, nothing ready
    repeat (3) rx_step(4'b1101, 4'b0000);

    // R5: pause and interleave; R2 lowest port wins
    for (int i = 0; i < 10; i++) rx_step(4'b1011, 4'b0101);
    repeat (3) rx_step(4'b1111, 4'b0101);
    for (int i = 0; i < 5; i++) rx_step(4'b1010, 4'b0101);
    for (int i = 0; i < CELL - 10; i++) rx_step(4'b1011, 4'b0001);
    for (int i = 0; i < CELL - 5; i++) rx_step(4'b1110, 4'b0000);
    rx_step(4'b1110, 4'b0000);

    // R6: idle float
    rx_float_idle = 1'b1;
    repeat (3) rx_step(4'b1111, 4'b0000);
    rx_step(4'b0111, 4'b0000);
    rx_step(4'b1111, 4'b0000);
    rx_float_idle = 1'b0;
    repeat (2) rx_step(4'b1111, 4'b0000);

    // Transmit side
    tx_perr_en = 4'b1000;
    // R9: stray bytes without start marker are dropped
    tx_step(4'b0111, 8'h11, 1'b0, 1'b0, 4'b0000);
    tx_step(4'b0111, 8'h22, 1'b0, 1'b0, 4'b0000);
    // R8 R9 R10: port 3 cell with one bad parity byte
    for (int i = 0; i < CELL; i++)
      tx_step(4'b0111, 8'(i * 3 + 1), (i == 0), (i == 5), 4'b0000);
    // R10: bad parity on port 1 with its enable off
    tx_step(4'b1101, 8'hA0, 1'b1, 1'b1, 4'b0000);
    // R9: pause
    repeat (2) tx_step(4'b1111, 8'h00, 1'b0, 1'b0, 4'b0000);
    // R9: start marker mid-cell restarts the count
    tx_step(4'b1101, 8'hB0, 1'b1, 1'b0, 4'b0000);
    for (int i = 1; i < CELL; i++)
      tx_step(4'b1101, 8'(8'hC0 + i), 1'b0, 1'b0, 4'b0000);
    // R8: ports 1 and 3 both enabled, port 1 wins
    tx_step(4'b0101, 8'h5D, 1'b1, 1'b0, 4'b0000);
    // R11: clear port 3 bit
    tx_step(4'b1111, 8'h00, 1'b0, 1'b0, 4'b1000);
    // R11: set and clear together, set wins
    tx_perr_en = 4'b1010;
    tx_step(4'b1101, 8'h3C, 1'b0, 1'b1, 4'b0010);
    tx_step(4'b1111, 8'h00, 1'b0, 1'b0, 4'b0010);
    repeat (3) tx_step(4'b1111, 8'h00, 1'b0, 1'b0, 4'b0000);

    // R2: pop counts per port
    for (int p = 0; p < N; p++) chk("R2 pop count", 32'(rptr[p]), 32'(erx_ptr[p]));
    chk("R2 rx scoreboard drained", 32'(rxq.size()), 0);
    chk("R8 tx scoreboard drained", 32'(txq.size()), 0);

    done = 1'b1;
    finish_run();
  end

endmodule